// File: doc/BRIEF.md
# Conversion Sequencing Controller

This block decides when a temperature sensor's converter runs. It owns a small configuration register, written and read over a simple parallel host port, that selects between free-running conversions and a low-power shutdown state. In the free-running case it issues a start pulse, waits for the converter's done pulse, latches the result and starts again. In shutdown it stays idle. A write that sets the one-shot bit while in shutdown runs a single conversion and then returns to shutdown.

The configuration fields for alert polarity mode, fault-queue depth and resolution are passed on to neighbouring logic. A one-cycle clear pulse goes to the alert logic whenever shutdown is entered and whenever a general-call reset arrives. The general-call reset returns every register in the block to its power-up value.

Top module: `conv_seq_ctrl`

## Requirements
- R1: A host write to the configuration address (2) with bit 7 (one-shot) and bit 0 (shutdown) both 1, made while the sequencer is idle in shutdown, raises `conv_start` in the cycle after the write. Exactly one conversion and one `new_sample` pulse follow.
- R2: While bit 0 of the configuration register is 1 and no one-shot is requested, including after a one-shot conversion has completed, `conv_start` stays low.
- R3: A read of address 2 returns 0 in bit 7 at all times. Bits 6:0 return the value last written: bit 6 spare, bits 5:4 resolution, bits 3:2 fault-queue select, bit 1 alert mode, bit 0 shutdown.
- R4: `alert_clr` pulses high for one cycle right after a write that changes bit 0 from 0 to 1, and right after a general-call reset.
- R5: A `gcall_rst` pulse returns the configuration register to 0x00 and the result to 0, with alert mode 0. It sends the sequencer to idle, after which continuous conversions resume.
- R6: With bit 0 clear, `conv_start` is a one-cycle pulse that rises again in the cycle after each accepted `conv_done`, so that consecutive starts are spaced one cycle more than the converter latency.
- R7: A write with bit 7 set and bit 0 clear starts nothing extra, leaves the start spacing unchanged and stores bit 7 nowhere.
- R8: If bit 0 is set while a conversion is in flight, that conversion completes and produces its `new_sample` pulse, and no further start follows.
- R9: After reset the configuration register reads 0x00 and `conv_res`, `fault_sel` and `alert_mode` are 0. They then follow bits 5:4, 3:2 and 1 of the register.
- R10: On an accepted `conv_done`, the result is latched on the same edge with a one-cycle `new_sample`. Address 0 reads result bits 11:4, and address 1 reads result bits 3:0 in its upper nibble with zeros below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gcall_rst | input | 1 | One-cycle general-call reset request |
| host_we | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational from address |
| conv_start | output | 1 | Start pulse to the converter |
| conv_done | input | 1 | Done pulse from the converter |
| conv_data | input | TEMP_W | Converter result, valid with done |
| conv_res | output | 2 | Resolution select to the converter |
| temp_out | output | TEMP_W | Latched result |
| new_sample | output | 1 | One-cycle strobe with each latched result |
| alert_mode | output | 1 | Alert mode field |
| fault_sel | output | 2 | Fault-queue select field |
| alert_clr | output | 1 | Clear request to the alert logic |

## Verification
A configuration write takes effect on the edge that samples it, so the register readback, the field outputs and `alert_clr` are due in the cycle after the write. A one-shot `conv_start` is also due in that cycle. A continuous restart appears one cycle after `conv_done`, together with the `new_sample` strobe and the updated result. Host reads are combinational. The bench drives inputs and samples outputs on the falling edge, and it measures the distance between starts against the model's latency for a sweep of latencies. Conversion counts are taken over windows long enough to contain every start that is due.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
    localparam int TMSB_ADDR = 0;
    localparam int TLSB_ADDR = 1;
    localparam int CFG_ADDR  = 2;

    typedef struct packed {
        logic       spare;
        logic [1:0] res;
        logic [1:0] fault;
        logic       amode;
        logic       shdn;
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_START = 2'd1,
        SEQ_BUSY  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/cs_cfg_reg.sv
module cs_cfg_reg
    import conv_seq_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gcall_rst,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output cfg_t              cfg,
    output logic              os_req,
    output logic              alert_clr
);
    typedef struct packed {
        cfg_t cfg;
        logic aclr;
    } cfg_state_t;

    cfg_state_t r_d, r_q;
    logic       cfg_wr;

    assign cfg_wr = host_we && (host_addr == ADDR_W'(CFG_ADDR));

    always_comb begin
        r_d      = r_q;
        r_d.aclr = 1'b0;
        if (gcall_rst) begin
            r_d.cfg  = '0;
            r_d.aclr = 1'b1;
        end else if (cfg_wr) begin
            r_d.cfg  = cfg_t'(host_wdata[CFG_W-1:0]);
            r_d.aclr = host_wdata[0] && !r_q.cfg.shdn;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cfg       = r_q.cfg;
    assign alert_clr = r_q.aclr;
    assign os_req    = cfg_wr && host_wdata[7] && host_wdata[0] && !gcall_rst;

    // R4
    shdn_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.cfg.shdn) |-> alert_clr);

    // R5
    gcall_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(gcall_rst) |-> (cfg == '0 && alert_clr));
endmodule

// File: rtl/cs_seq_fsm.sv
module cs_seq_fsm
    import conv_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic gcall_rst,
    input  logic shdn,
    input  logic os_req,
    input  logic conv_done,
    output logic conv_start,
    output logic accept
);
    typedef struct packed {
        seq_state_e st;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        accept = 1'b0;
        if (gcall_rst) begin
            s_d.st = SEQ_IDLE;
        end else begin
            case (s_q.st)
                SEQ_IDLE:  if (!shdn || os_req) s_d.st = SEQ_START;
                SEQ_START: s_d.st = SEQ_BUSY;
                SEQ_BUSY: begin
                    if (conv_done) begin
                        accept = 1'b1;
                        s_d.st = shdn ? SEQ_IDLE : SEQ_START;
                    end
                end
                default:   s_d.st = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SEQ_IDLE};
        else        s_q <= s_d;
    end

    assign conv_start = (s_q.st == SEQ_START);

    // R6
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);

    // R6
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SEQ_BUSY && conv_done && !shdn && !gcall_rst) |=> conv_start);

    // R1
    oneshot_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SEQ_IDLE && os_req) |=> conv_start);

    // R2
    shdn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SEQ_IDLE && shdn && !os_req) |=> !conv_start);
endmodule

// File: rtl/cs_result_reg.sv
module cs_result_reg #(
    parameter int TEMP_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gcall_rst,
    input  logic              accept,
    input  logic [TEMP_W-1:0] conv_data,
    output logic [TEMP_W-1:0] temp,
    output logic              new_sample
);
    typedef struct packed {
        logic [TEMP_W-1:0] temp;
        logic              fresh;
    } res_t;

    res_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.fresh = 1'b0;
        if (gcall_rst) begin
            r_d = '0;
        end else if (accept) begin
            r_d.temp  = conv_data;
            r_d.fresh = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign temp       = r_q.temp;
    assign new_sample = r_q.fresh;

    // R10
    sample_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        new_sample |=> !new_sample);

    // R10
    temp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!new_sample && !$past(gcall_rst)) |-> $stable(temp));
endmodule

// File: rtl/conv_seq_ctrl.sv
module conv_seq_ctrl
    import conv_seq_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int TEMP_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gcall_rst,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              conv_start,
    input  logic              conv_done,
    input  logic [TEMP_W-1:0] conv_data,
    output logic [1:0]        conv_res,
    output logic [TEMP_W-1:0] temp_out,
    output logic              new_sample,
    output logic              alert_mode,
    output logic [1:0]        fault_sel,
    output logic              alert_clr
);
    localparam int LO_W  = TEMP_W - 8;
    localparam int PAD_W = 8 - LO_W;

    cfg_t cfg;
    logic os_req;
    logic accept;

    cs_cfg_reg #(.ADDR_W(ADDR_W)) cfg_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .gcall_rst  (gcall_rst),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .cfg        (cfg),
        .os_req     (os_req),
        .alert_clr  (alert_clr)
    );

    cs_seq_fsm seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .gcall_rst  (gcall_rst),
        .shdn       (cfg.shdn),
        .os_req     (os_req),
        .conv_done  (conv_done),
        .conv_start (conv_start),
        .accept     (accept)
    );

    cs_result_reg #(.TEMP_W(TEMP_W)) res_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .gcall_rst  (gcall_rst),
        .accept     (accept),
        .conv_data  (conv_data),
        .temp       (temp_out),
        .new_sample (new_sample)
    );

    always_comb begin
        host_rdata = '0;
        if (host_addr == ADDR_W'(TMSB_ADDR))
            host_rdata = temp_out[TEMP_W-1 -: 8];
        else if (host_addr == ADDR_W'(TLSB_ADDR))
            host_rdata = {temp_out[LO_W-1:0], {PAD_W{1'b0}}};
        else if (host_addr == ADDR_W'(CFG_ADDR))
            host_rdata = {1'b0, cfg};
    end

    assign conv_res   = cfg.res;
    assign fault_sel  = cfg.fault;
    assign alert_mode = cfg.amode;

    // R3
    os_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == ADDR_W'(CFG_ADDR)) |-> !host_rdata[7]);
endmodule

// File: tb/conv_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module conv_seq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        gcall_rst = 1'b0;
    logic        host_we = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic [7:0]  host_wdata = 8'd0;
    logic [7:0]  host_rdata;
    logic        conv_start;
    logic        conv_done;
    logic [11:0] conv_data;
    logic [1:0]  conv_res;
    logic [11:0] temp_out;
    logic        new_sample;
    logic        alert_mode;
    logic [1:0]  fault_sel;
    logic        alert_clr;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int lat = 2;
    int mcnt = 0;
    logic [11:0] mdata = '0;
    int start_cnt = 0;
    int sample_cnt = 0;
    int last_start = 0;
    bit have_last = 0;
    bit per_chk = 0;

    always #5 clk = ~clk;

    conv_seq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .gcall_rst(gcall_rst),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .conv_start(conv_start), .conv_done(conv_done),
        .conv_data(conv_data), .conv_res(conv_res), .temp_out(temp_out),
        .new_sample(new_sample), .alert_mode(alert_mode), .fault_sel(fault_sel),
        .alert_clr(alert_clr)
    );

    assign conv_data = mdata;

    // converter model: done arrives lat edges after the start is seen
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            mcnt <= 0;
            conv_done <= 1'b0;
        end else begin
            conv_done <= 1'b0;
            if (conv_start) begin
                if (lat == 1) begin
                    conv_done <= 1'b1;
                    mdata <= mdata + 12'h29B;
                    mcnt <= 0;
                end else begin
                    mcnt <= lat - 1;
                end
            end else if (mcnt != 0) begin
                mcnt <= mcnt - 1;
                if (mcnt == 1) begin
                    conv_done <= 1'b1;
                    mdata <= mdata + 12'h29B;
                end
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor on falling edges
    always @(negedge clk) begin
        if (rst_n) begin
            if (conv_start) begin
                if (per_chk && have_last)
                    chk("R6 start spacing", cyc - last_start, lat + 1);
                last_start = cyc;
                have_last = 1;
                start_cnt++;
            end
            if (new_sample) begin
                sample_cnt++;
                chk("R10 latched result", int'(temp_out), int'(mdata));
            end
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        logic [7:0] rv;
        int s0, n0;
        idle(4);
        chk("R9 start low in reset", int'(conv_start), 0);
        rd(2'd2, rv); chk("R9 cfg reset value", int'(rv), 0);
        rd(2'd0, rv); chk("R9 result reset value", int'(rv), 0);
        chk("R9 fields at reset", int'({conv_res, fault_sel, alert_mode}), 0);
        rst_n = 1'b1;
        per_chk = 1;
        idle(30);
        chk("R6 free-running after reset", int'(start_cnt >= 8), 1);

        // R6: latency sweep
        for (int l = 1; l <= 5; l++) begin
            wr(2'd2, 8'h01);
            chk("R4 clear on shutdown entry", int'(alert_clr), 1);
            per_chk = 0;
            idle(12);
            lat = l; have_last = 0; per_chk = 1;
            s0 = start_cnt;
            wr(2'd2, 8'h00);
            chk("R4 no clear on shutdown exit", int'(alert_clr), 0);
            idle(8 * (l + 1) + 4);
            chk("R6 starts in window", int'(start_cnt - s0 >= 8), 1);
        end

        // R1 / R2: one-shot in shutdown for several latencies
        for (int l = 1; l <= 3; l++) begin
            wr(2'd2, 8'h01);
            per_chk = 0;
            idle(12);
            lat = l;
            s0 = start_cnt; n0 = sample_cnt;
            idle(10);
            chk("R2 idle in shutdown", start_cnt - s0, 0);
            wr(2'd2, 8'h81);
            rd(2'd2, rv); chk("R3 one-shot bit reads zero", int'(rv), 8'h01);
            idle(5 * (l + 1) + 10);
            chk("R1 single start", start_cnt - s0, 1);
            chk("R1 single sample", sample_cnt - n0, 1);
            idle(15);
            chk("R2 back in shutdown", start_cnt - s0, 1);
            rd(2'd0, rv); chk("R10 result high byte", int'(rv), int'(mdata[11:4]));
            rd(2'd1, rv); chk("R10 result low byte", int'(rv), int'({mdata[3:0], 4'b0}));
        end

        // R7: one-shot bit with shutdown clear
        lat = 2;
        have_last = 0; per_chk = 1;
        wr(2'd2, 8'h00);
        idle(10);
        s0 = start_cnt;
        wr(2'd2, 8'h80);
        rd(2'd2, rv); chk("R7 bit 7 not stored", int'(rv), 0);
        idle(30);
        chk("R7 spacing kept", int'(start_cnt - s0 >= 9 && start_cnt - s0 <= 11), 1);

        // R8: shutdown during a conversion
        per_chk = 0;
        lat = 3;
        idle(10);
        @(negedge clk);
        while (!conv_start) @(negedge clk);
        #1;
        s0 = start_cnt; n0 = sample_cnt;
        wr(2'd2, 8'h01);
        idle(20);
        chk("R8 in-flight sample delivered", sample_cnt - n0, 1);
        chk("R8 no start after", start_cnt - s0, 0);

        // R3 / R9: field readback
        wr(2'd2, 8'h7B);
        rd(2'd2, rv); chk("R3 cfg readback", int'(rv), 8'h7B);
        chk("R9 resolution field", int'(conv_res), 3);
        chk("R9 fault field", int'(fault_sel), 2);
        chk("R9 alert mode field", int'(alert_mode), 1);

        // R5: general-call reset
        @(negedge clk); gcall_rst = 1'b1;
        @(negedge clk); gcall_rst = 1'b0;
        chk("R5 clear to alert logic", int'(alert_clr), 1);
        rd(2'd2, rv); chk("R5 cfg restored", int'(rv), 0);
        rd(2'd0, rv); chk("R5 result cleared", int'(rv), 0);
        chk("R5 alert mode back to 0", int'(alert_mode), 0);
        s0 = start_cnt;
        idle(20);
        chk("R5 continuous resumes", int'(start_cnt - s0 >= 3), 1);

        wr(2'd2, 8'h01);
        idle(10);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #1500000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule